// File: doc/BRIEF.md
# Multi-Mode Tick Timer

A cycle-counting timer for operating-system scheduling ticks and for measuring elapsed time. The counter is a free 32-bit register. Software sets a compare value and picks one of four modes through a small word-addressed register port. When the count equals the compare value, the timer sets a sticky pending flag. That flag, gated by an enable bit, drives the interrupt line.

In the restart mode the count returns to zero after each hit, which gives a periodic tick of compare+1 cycles. In the one-shot mode the count freezes on the hit, so the frozen value gives a measurement. In the free mode the count keeps running through the hit and wraps around. Software can load the counter at any moment, and that load wins over the counter's own update.

Top module: `tick_timer`

## Requirements
- R1: After reset, the count, the compare value and the control word all read 0, and `irq_o` is 0.
- R2: Register selects are: address 0 for the count, address 1 for the compare value, address 2 for the control word, where bits [1:0] hold the mode, bit 2 the interrupt enable and bit 3 the pending flag. Other addresses read 0 and ignore writes. Read data follows the address in the same cycle, and unused control bits read 0.
- R3: Mode 00 (off) holds the count and never sets the pending flag, even when the count equals the compare value.
- R4: Mode 01 (restart) adds one per cycle. In a cycle where the count equals the compare value, the next edge loads 0 and sets the pending flag.
- R5: Mode 10 (one-shot) adds one per cycle until the count equals the compare value. It then holds that value and sets the pending flag once. It stays halted until software writes the count or the control word.
- R6: Mode 11 (free) adds one every cycle, wraps from all-ones to 0, and sets the pending flag at the edge that follows a cycle where the count equals the compare value.
- R7: The pending flag is sticky. Writing the control word with bit 3 at 0 clears it, and writing 1 there never sets it. A hit in the same cycle as a clearing write leaves it set.
- R8: `irq_o` is high exactly when both the pending flag and the enable bit are set. With the enable bit at 0, the pending flag still sets.
- R9: A write to the count takes effect at the next edge in every mode, replacing the increment or the restart of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | AW (2) | Register select |
| reg_wdata | input | W (32) | Write data |
| reg_rdata | output | W (32) | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
Every cycle, the checker tracks the per-mode step of the count: holding in off, reloading zero after a hit in restart, freezing at the hit in one-shot, and adding one in free. It also watches that a count write overrides all of these and that the pending flag only falls on a clearing write. The stimulus scenarios are the only way to show the rest. They cover the cycle in which a hit becomes visible, wrap at all-ones, the one-shot resuming after a reload, and a clear colliding with a hit. They also cover masking and unmasking a pending flag, ignored addresses, and reset in the middle of a run.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      TM_OFF     = 2'b00,
      TM_RESTART = 2'b01,
      TM_ONESHOT = 2'b10,
      TM_FREE    = 2'b11
   } tmode_e;

   localparam int SEL_COUNT = 0;
   localparam int SEL_CMP   = 1;
   localparam int SEL_CTRL  = 2;

   localparam int CTRL_IE_BIT   = 2;
   localparam int CTRL_PEND_BIT = 3;
   localparam int CTRL_BITS     = 4;

endpackage

// File: rtl/tt_regfile.sv
module tt_regfile
   import tick_timer_pkg::*;
#(
   parameter int W        = 32,
   parameter int AW       = 2,
   parameter bit READ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  count,
   input  logic          pending,
   output logic [W-1:0]  compare,
   output tmode_e        mode,
   output logic          irq_en,
   output logic          cnt_wr,
   output logic          ctl_wr,
   output logic          clr_pend,
   output logic [W-1:0]  rdata
);

   localparam logic [AW-1:0] A_COUNT = AW'(SEL_COUNT);
   localparam logic [AW-1:0] A_CMP   = AW'(SEL_CMP);
   localparam logic [AW-1:0] A_CTRL  = AW'(SEL_CTRL);
   localparam int            PAD     = W - CTRL_BITS;

   logic          cmp_wr;
   logic [W-1:0]  rd_mux;

   assign cnt_wr   = wr_en && (addr == A_COUNT);
   assign cmp_wr   = wr_en && (addr == A_CMP);
   assign ctl_wr   = wr_en && (addr == A_CTRL);
   assign clr_pend = ctl_wr && !wdata[CTRL_PEND_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         compare <= '0;
      end else if (cmp_wr) begin
         compare <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= TM_OFF;
         irq_en <= 1'b0;
      end else if (ctl_wr) begin
         mode   <= tmode_e'(wdata[1:0]);
         irq_en <= wdata[CTRL_IE_BIT];
      end
   end

   always_comb begin
      unique case (addr)
         A_COUNT: rd_mux = count;
         A_CMP:   rd_mux = compare;
         A_CTRL:  rd_mux = {{PAD{1'b0}}, pending, irq_en, mode};
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate

endmodule

// File: rtl/tt_counter.sv
module tt_counter
   import tick_timer_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmode_e       mode,
   input  logic [W-1:0] compare,
   input  logic         cnt_wr,
   input  logic         ctl_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] count,
   output logic         hit
);

   localparam logic [W-1:0] ONE = W'(1);

   logic          halted;
   logic          equal;
   logic [W-1:0]  count_nx;

   assign equal = (count == compare);
   assign hit   = (mode != TM_OFF) && equal && !halted;

   always_comb begin
      count_nx = count;
      if (cnt_wr) begin
         count_nx = wdata;
      end else begin
         unique case (mode)
            TM_OFF:     count_nx = count;
            TM_RESTART: count_nx = hit ? '0 : count + ONE;
            TM_ONESHOT: count_nx = (hit || halted) ? count : count + ONE;
            TM_FREE:    count_nx = count + ONE;
            default:    count_nx = count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted <= 1'b0;
      end else if (cnt_wr || ctl_wr) begin
         halted <= 1'b0;
      end else if (mode == TM_ONESHOT && hit) begin
         halted <= 1'b1;
      end
   end

endmodule

// File: rtl/tt_irq.sv
module tt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr_pend,
   input  logic irq_en,
   output logic pending,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending <= 1'b0;
      else if (hit)      pending <= 1'b1;
      else if (clr_pend) pending <= 1'b0;
   end

   assign irq = pending & irq_en;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int W        = 32,
   parameter int AW       = 2,
   parameter bit READ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [W-1:0]  reg_wdata,
   output logic [W-1:0]  reg_rdata,
   output logic          irq_o
);

   generate
      if (W < CTRL_BITS || W > 64) begin : g_bad_width
         $error("tick_timer: W must lie in 4..64");
      end
      if (AW < 2 || AW > 8) begin : g_bad_addr
         $error("tick_timer: AW must lie in 2..8");
      end
   endgenerate

   logic [W-1:0] count_q;
   logic [W-1:0] compare_q;
   tmode_e       mode_q;
   logic         ie_q;
   logic         pend_q;
   logic         cnt_wr;
   logic         ctl_wr;
   logic         clr_pend;
   logic         hit;

   tt_regfile #(.W(W), .AW(AW), .READ_REG(READ_REG)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .count    (count_q),
      .pending  (pend_q),
      .compare  (compare_q),
      .mode     (mode_q),
      .irq_en   (ie_q),
      .cnt_wr   (cnt_wr),
      .ctl_wr   (ctl_wr),
      .clr_pend (clr_pend),
      .rdata    (reg_rdata)
   );

   tt_counter #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .compare (compare_q),
      .cnt_wr  (cnt_wr),
      .ctl_wr  (ctl_wr),
      .wdata   (reg_wdata),
      .count   (count_q),
      .hit     (hit)
   );

   tt_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .clr_pend (clr_pend),
      .irq_en   (ie_q),
      .pending  (pend_q),
      .irq      (irq_o)
   );

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
   import tick_timer_pkg::*;
#(
   parameter int W  = 32,
   parameter int AW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] addr,
   input logic [W-1:0]  wdata,
   input logic [W-1:0]  count,
   input logic [W-1:0]  compare,
   input logic [1:0]    mode,
   input logic          pending
);

   logic load_cnt;
   logic clear_wr;

   assign load_cnt = wr_en && (addr == AW'(SEL_COUNT));
   assign clear_wr = wr_en && (addr == AW'(SEL_CTRL)) && !wdata[CTRL_PEND_BIT];

   assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !load_cnt) |=> (count == $past(count)));

   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && count == compare && !load_cnt) |=> (count == '0));

   assert_restart_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && count == compare) |=> pending);

   assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && count == compare && !load_cnt) |=> (count == $past(count)));

   assert_free_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && !load_cnt) |=> (count == W'($past(count) + W'(1))));

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !clear_wr) |=> pending);

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_cnt |=> (count == $past(wdata)));

endmodule

bind tick_timer tick_timer_checker #(.W(W), .AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (reg_wr),
   .addr    (reg_addr),
   .wdata   (reg_wdata),
   .count   (count_q),
   .compare (compare_q),
   .mode    (mode_q),
   .pending (pend_q)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   tick_timer u_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic        ie;
      logic [31:0] cmp;
      logic [31:0] start;
      logic [7:0]  wait_n;
      logic [31:0] exp_cnt;
      logic        exp_pend;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{2'b01, 1'b1, 32'd5,          32'd0,          8'd3,  32'd3,  1'b0},
      '{2'b01, 1'b1, 32'd5,          32'd0,          8'd6,  32'd0,  1'b1},
      '{2'b01, 1'b0, 32'd5,          32'd0,          8'd9,  32'd3,  1'b1},
      '{2'b10, 1'b1, 32'd4,          32'd0,          8'd4,  32'd4,  1'b0},
      '{2'b10, 1'b1, 32'd4,          32'd0,          8'd10, 32'd4,  1'b1},
      '{2'b11, 1'b1, 32'd3,          32'd0,          8'd8,  32'd8,  1'b1},
      '{2'b11, 1'b0, 32'd100,        32'hFFFF_FFFE,  8'd3,  32'd1,  1'b0},
      '{2'b11, 1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFD,  8'd4,  32'd1,  1'b1},
      '{2'b00, 1'b1, 32'd2,          32'd7,          8'd5,  32'd7,  1'b0},
      '{2'b00, 1'b1, 32'd7,          32'd7,          8'd5,  32'd7,  1'b0},
      '{2'b01, 1'b1, 32'd0,          32'd0,          8'd3,  32'd0,  1'b1},
      '{2'b01, 1'b1, 32'd2,          32'd10,         8'd3,  32'd13, 1'b0},
      '{2'b10, 1'b1, 32'd4,          32'd6,          8'd3,  32'd9,  1'b0}
   };

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'b00:   return "R3";
         2'b01:   return "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input logic [1:0] m, input logic ie, input logic [31:0] c,
                        input logic [31:0] s);
      wr(2'd2, 32'h0);
      wr(2'd2, 32'h0);
      wr(2'd1, c);
      wr(2'd0, s);
      wr(2'd2, {29'd0, ie, m});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      summary();
   end

   initial begin
      logic [31:0] v;

      idle(3);
      // R1: state straight after reset
      rd(2'd0, v); check("R1 count", v, 32'd0);
      rd(2'd1, v); check("R1 compare", v, 32'd0);
      rd(2'd2, v); check("R1 ctrl", v, 32'd0);
      check("R1 irq", {31'd0, irq_o}, 32'd0);
      rst_n = 1'b1;
      idle(1);

      for (int i = 0; i < NV; i++) begin
         setup(VECS[i].mode, VECS[i].ie, VECS[i].cmp, VECS[i].start);
         idle(int'(VECS[i].wait_n));
         rd(2'd0, v);
         check(mode_tag(VECS[i].mode), v, VECS[i].exp_cnt);
         rd(2'd2, v);
         check("R7 pending", {31'd0, v[3]}, {31'd0, VECS[i].exp_pend});
         check("R8 irq", {31'd0, irq_o}, {31'd0, VECS[i].exp_pend & VECS[i].ie});
      end

      // R9: a count load replaces the free-mode increment
      setup(2'b11, 1'b0, 32'hFFFF_0000, 32'd0);
      idle(5);
      wr(2'd0, 32'h50);
      rd(2'd0, v); check("R9 load", v, 32'h50);
      idle(1);
      rd(2'd0, v); check("R9 after load", v, 32'h51);

      // R5: one-shot resumes after a count write, then halts again
      setup(2'b10, 1'b0, 32'd4, 32'd0);
      idle(8);
      rd(2'd0, v); check("R5 halted", v, 32'd4);
      wr(2'd0, 32'd1);
      idle(2);
      rd(2'd0, v); check("R5 resumed", v, 32'd3);
      idle(5);
      rd(2'd0, v); check("R5 halted again", v, 32'd4);

      // R7: a hit in the same cycle as a clearing write keeps the flag
      setup(2'b01, 1'b0, 32'd0, 32'd0);
      idle(2);
      wr(2'd2, 32'h1);
      rd(2'd2, v); check("R7 hit beats clear", {31'd0, v[3]}, 32'd1);
      check("R8 masked", {31'd0, irq_o}, 32'd0);

      // R7: writing 1 to the flag does not set it
      wr(2'd2, 32'h0);
      wr(2'd2, 32'h0);
      wr(2'd2, 32'h8);
      rd(2'd2, v); check("R7 write one", {31'd0, v[3]}, 32'd0);

      // R8: a masked pending flag raises irq once enabled, drops when cleared
      setup(2'b11, 1'b0, 32'd2, 32'd0);
      idle(4);
      check("R8 pending masked", {31'd0, irq_o}, 32'd0);
      wr(2'd2, 32'hF);
      check("R8 unmasked", {31'd0, irq_o}, 32'd1);
      wr(2'd2, 32'h7);
      check("R8 cleared", {31'd0, irq_o}, 32'd0);

      // R2: unused address reads 0 and ignores writes
      setup(2'b00, 1'b0, 32'h1234, 32'hABCD);
      rd(2'd3, v); check("R2 addr3 read", v, 32'd0);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R2 count kept", v, 32'hABCD);
      rd(2'd1, v); check("R2 compare kept", v, 32'h1234);
      rd(2'd2, v); check("R2 ctrl kept", v, 32'd0);
      wr(2'd2, 32'hFFFF_FFF6);
      rd(2'd2, v); check("R2 ctrl fields", v, 32'h6);

      // R1: reset in the middle of a run
      setup(2'b11, 1'b1, 32'd3, 32'd0);
      idle(6);
      rst_n = 1'b0;
      idle(2);
      rd(2'd0, v); check("R1 count mid", v, 32'd0);
      rd(2'd1, v); check("R1 compare mid", v, 32'd0);
      rd(2'd2, v); check("R1 ctrl mid", v, 32'd0);
      check("R1 irq mid", {31'd0, irq_o}, 32'd0);
      rst_n = 1'b1;
      idle(2);

      summary();
   end

endmodule